// File: doc/BRIEF.md
# Configurable Programmable Logic Array

This block is a sum-of-products array whose AND plane and OR plane are both set at run time. Every product term holds a two-bit connection code for each primary input and a one-bit connection for each output. A term is the AND of its selected literals. Each output is the OR of every term connected to it. Because the OR plane can be programmed, one term can feed any number of outputs and is built only once.

Configuration is written one term per cycle. A write carries the term index, the packed input codes and the output mask, and it lands on the next rising clock edge. Between writes the primary inputs flow through both planes combinationally to the outputs. After reset every term is disabled and every mask is empty, so all outputs read 0 until the array is programmed. The default build has 3 inputs, 5 terms and 4 outputs. That is enough for a four-output function set that shares its terms, for example F0=A+B'C', F1=AC'+AB, F2=B'C'+AB and F3=B'C+A.

Top module: `pla_array`

## Requirements
- R1: While rst_ni is low, and after it is released with no writes, every term holds the kill code and every output mask is empty, so out_o is 0 for every input pattern.
- R2: Input k of a term is coded in cfg_and_i bits [2k+1:2k]. Code 00 leaves the input out of the term, 01 requires in_i[k]=1, and 10 requires in_i[k]=0.
- R3: Code 11 on any input forces its term to 0, whatever the other codes and inputs are.
- R4: A term whose codes are all 00 is constant 1, and every output connected to it is constant 1.
- R5: An output with no term connected in its mask column is constant 0.
- R6: Bit j of cfg_or_i connects the term to out_o[j]. One term may drive several outputs at once, and each output is the OR of its connected terms.
- R7: A write with cfg_we_i high takes effect at the next rising edge of clk_i. Until that edge the outputs still follow the old matrix. Outside writes, out_o follows in_i combinationally.
- R8: A write whose cfg_term_i is N_TERM or above changes no term.
- R9: A write to one term leaves every other term's codes and mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for one term |
| cfg_term_i | input | TIDX_W | Index of the term to write |
| cfg_and_i | input | 2*N_IN | Input connection codes, two bits per input |
| cfg_or_i | input | N_OUT | Output connection mask of the term |
| in_i | input | N_IN | Primary inputs |
| out_o | output | N_OUT | Sum-of-products outputs |

## Verification
The hardest case to reach from the ports is a term whose kill code sits next to true and complement literals. The OR of its outputs must show that one code overrides literals that would otherwise be satisfied. The bench programs such a term onto every output, with every other term left killed by reset, and sweeps all input patterns. The shared-term case is covered by loading the full five-term example. Each output is then compared with its hand-written formula as well as with a software evaluation of the stored matrix. Out-of-range and single-row rewrites come after that, so any change to the other rows would show up in the next full input sweep.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic [1:0] {
    LIT_NONE = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_COMP = 2'b10,
    LIT_KILL = 2'b11
  } lit_code_e;

  function automatic logic lit_eval(lit_code_e code, logic x);
    case (code)
      LIT_NONE: return 1'b1;
      LIT_TRUE: return x;
      LIT_COMP: return ~x;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4,
  parameter int TIDX_W = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_we_i,
  input  logic [TIDX_W-1:0]         cfg_term_i,
  input  logic [2*N_IN-1:0]         cfg_and_i,
  input  logic [N_OUT-1:0]          cfg_or_i,
  output logic [N_TERM*2*N_IN-1:0]  and_flat_o,
  output logic [N_TERM*N_OUT-1:0]   or_flat_o
);
  localparam int AW = 2 * N_IN;

  for (genvar t = 0; t < N_TERM; t++) begin : g_row
    logic          row_we;
    logic [AW-1:0] and_q;
    logic [N_OUT-1:0] or_q;

    // indices at or above N_TERM match no row
    assign row_we = cfg_we_i && (cfg_term_i == TIDX_W'(t));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        and_q <= '1;   // kill code on every input
        or_q  <= '0;
      end else if (row_we) begin
        and_q <= cfg_and_i;
        or_q  <= cfg_or_i;
      end
    end

    assign and_flat_o[t*AW +: AW]      = and_q;
    assign or_flat_o[t*N_OUT +: N_OUT] = or_q;
  end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5
) (
  input  logic [N_TERM*2*N_IN-1:0] and_flat_i,
  input  logic [N_IN-1:0]          in_i,
  output logic [N_TERM-1:0]        prod_o
);
  localparam int AW = 2 * N_IN;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic hit;
    always_comb begin
      hit = 1'b1;
      for (int k = 0; k < N_IN; k++) begin
        hit = hit & lit_eval(lit_code_e'(and_flat_i[t*AW + 2*k +: 2]), in_i[k]);
      end
    end
    assign prod_o[t] = hit;
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4
) (
  input  logic [N_TERM*N_OUT-1:0] or_flat_i,
  input  logic [N_TERM-1:0]       prod_i,
  output logic [N_OUT-1:0]        out_o
);
  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    logic [N_TERM-1:0] col;
    for (genvar t = 0; t < N_TERM; t++) begin : g_bit
      assign col[t] = or_flat_i[t*N_OUT + j];
    end
    assign out_o[j] = |(col & prod_i);
  end
endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter  int N_IN   = 3,
  parameter  int N_TERM = 5,
  parameter  int N_OUT  = 4,
  localparam int TIDX_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [TIDX_W-1:0] cfg_term_i,
  input  logic [2*N_IN-1:0] cfg_and_i,
  input  logic [N_OUT-1:0]  cfg_or_i,
  input  logic [N_IN-1:0]   in_i,
  output logic [N_OUT-1:0]  out_o
);
  logic [N_TERM*2*N_IN-1:0] and_flat;
  logic [N_TERM*N_OUT-1:0]  or_flat;
  logic [N_TERM-1:0]        prod;

  pla_cfg_store #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .TIDX_W(TIDX_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_term_i (cfg_term_i),
    .cfg_and_i  (cfg_and_i),
    .cfg_or_i   (cfg_or_i),
    .and_flat_o (and_flat),
    .or_flat_o  (or_flat)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .and_flat_i (and_flat),
    .in_i       (in_i),
    .prod_o     (prod)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .or_flat_i (or_flat),
    .prod_i    (prod),
    .out_o     (out_o)
  );
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter  int N_IN   = 3,
  parameter  int N_TERM = 5,
  parameter  int N_OUT  = 4,
  localparam int TIDX_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cfg_we_i,
  input logic [TIDX_W-1:0]        cfg_term_i,
  input logic [2*N_IN-1:0]        cfg_and_i,
  input logic [N_OUT-1:0]         cfg_or_i,
  input logic [N_OUT-1:0]         out_o,
  input logic [N_TERM*2*N_IN-1:0] and_flat_i,
  input logic [N_TERM*N_OUT-1:0]  or_flat_i,
  input logic [N_TERM-1:0]        prod_i
);
  localparam int AW = 2 * N_IN;

  logic bad_idx;
  assign bad_idx = int'(cfg_term_i) >= N_TERM;

  assert_oob_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && bad_idx) |=> ($stable(and_flat_i) && $stable(or_flat_i)));

  for (genvar t = 0; t < N_TERM; t++) begin : g_t
    logic killed;
    always_comb begin
      killed = 1'b0;
      for (int k = 0; k < N_IN; k++) begin
        killed = killed | (and_flat_i[t*AW + 2*k +: 2] == 2'b11);
      end
    end

    assert_kill_forces_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      killed |-> !prod_i[t]);

    assert_write_lands_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && int'(cfg_term_i) == t) |=>
        (and_flat_i[t*AW +: AW] == $past(cfg_and_i) &&
         or_flat_i[t*N_OUT +: N_OUT] == $past(cfg_or_i)));

    assert_other_rows_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && int'(cfg_term_i) != t) |=>
        ($stable(and_flat_i[t*AW +: AW]) && $stable(or_flat_i[t*N_OUT +: N_OUT])));

    for (genvar j = 0; j < N_OUT; j++) begin : g_j
      assert_term_drives_out_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prod_i[t] && or_flat_i[t*N_OUT + j]) |-> out_o[j]);
    end
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_o
    logic any_conn;
    always_comb begin
      any_conn = 1'b0;
      for (int t = 0; t < N_TERM; t++) any_conn = any_conn | or_flat_i[t*N_OUT + j];
    end
    assert_empty_col_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !any_conn |-> !out_o[j]);
  end
endmodule

bind pla_array pla_array_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_term_i (cfg_term_i),
  .cfg_and_i  (cfg_and_i),
  .cfg_or_i   (cfg_or_i),
  .out_o      (out_o),
  .and_flat_i (and_flat),
  .or_flat_i  (or_flat),
  .prod_i     (prod)
);

// File: tb/pla_array_bench.sv
module pla_array_bench;
  localparam int NI = 3, NT = 5, NO = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [2:0] cfg_term_i = '0;
  logic [5:0] cfg_and_i = '0;
  logic [3:0] cfg_or_i = '0;
  logic [2:0] in_i = '0;
  logic [3:0] out_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [5:0] m_and [NT];
  logic [3:0] m_or  [NT];

  always #2 clk_i = ~clk_i;

  pla_array u_pla_array (.*);

  function automatic logic [3:0] ref_out(logic [2:0] x);
    logic [3:0] r = '0;
    for (int t = 0; t < NT; t++) begin
      logic p = 1'b1;
      for (int k = 0; k < NI; k++) begin
        case (m_and[t][2*k +: 2])
          2'b00: ;
          2'b01: p &= x[k];
          2'b10: p &= ~x[k];
          default: p = 1'b0;
        endcase
      end
      if (p) r |= m_or[t];
    end
    return r;
  endfunction

  // A=in[0], B=in[1], C=in[2]
  function automatic logic [3:0] ex_out(logic [2:0] x);
    logic a = x[0], b = x[1], c = x[2];
    return {(~b & c) | a, (~b & ~c) | (a & b), (a & ~c) | (a & b), a | (~b & ~c)};
  endfunction

  task automatic chk(logic [3:0] act, logic [3:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s in=%b actual=%b expected=%b", tag, in_i, act, exp);
    end
  endtask

  task automatic sweep(string tag);
    for (int p = 0; p < 8; p++) begin
      in_i = 3'(p);
      #1;
      chk(out_o, ref_out(3'(p)), tag);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int t = 0; t < NT; t++) begin m_and[t] = '1; m_or[t] = '0; end
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic prog(int t, logic [5:0] a, logic [3:0] o);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_term_i = 3'(t); cfg_and_i = a; cfg_or_i = o;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (t < NT) begin m_and[t] = a; m_or[t] = o; end
  endtask

  task automatic test_reset();
    do_reset();
    for (int p = 0; p < 8; p++) begin
      in_i = 3'(p); #1;
      chk(out_o, 4'b0000, "R1");
    end
  endtask

  task automatic test_example();
    do_reset();
    prog(0, 6'b00_01_01, 4'b0110); // AB
    prog(1, 6'b01_10_00, 4'b1000); // B'C
    prog(2, 6'b10_00_01, 4'b0010); // AC'
    prog(3, 6'b10_10_00, 4'b0101); // B'C'
    prog(4, 6'b00_00_01, 4'b1001); // A
    for (int p = 0; p < 8; p++) begin
      in_i = 3'(p); #1;
      chk(out_o, ex_out(3'(p)), "R2_R6");
    end
    sweep("R6");
  endtask

  task automatic test_const();
    do_reset();
    prog(0, 6'b00_00_00, 4'b0001);
    for (int p = 0; p < 8; p++) begin
      in_i = 3'(p); #1;
      chk(out_o & 4'b0001, 4'b0001, "R4");
      chk(out_o & 4'b1110, 4'b0000, "R5");
    end
  endtask

  task automatic test_kill();
    do_reset();
    prog(2, 6'b01_11_10, 4'b1111);
    prog(3, 6'b11_00_00, 4'b1111);
    for (int p = 0; p < 8; p++) begin
      in_i = 3'(p); #1;
      chk(out_o, 4'b0000, "R3");
    end
  endtask

  task automatic test_timing();
    do_reset();
    in_i = 3'b000;
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_term_i = 3'd1; cfg_and_i = 6'b00_00_00; cfg_or_i = 4'b1010;
    #1;
    chk(out_o, 4'b0000, "R7_before_edge");
    @(posedge clk_i);
    #1;
    chk(out_o, 4'b1010, "R7_after_edge");
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    m_and[1] = 6'b00_00_00; m_or[1] = 4'b1010;
    prog(1, 6'b00_00_01, 4'b0100); // A only
    in_i = 3'b001; #1;
    chk(out_o, 4'b0100, "R7_comb_hi");
    in_i = 3'b110; #1;
    chk(out_o, 4'b0000, "R7_comb_lo");
  endtask

  task automatic test_range();
    test_example();
    prog(5, 6'b00_00_00, 4'b1111);
    prog(7, 6'b00_00_00, 4'b1111);
    for (int p = 0; p < 8; p++) begin
      in_i = 3'(p); #1;
      chk(out_o, ex_out(3'(p)), "R8");
    end
  endtask

  task automatic test_isolate();
    test_example();
    prog(2, 6'b01_00_00, 4'b0001); // C -> F0
    sweep("R9");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    test_reset();
    test_example();
    test_const();
    test_kill();
    test_timing();
    test_range();
    test_isolate();
    finish_run();
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule